// File: doc/BRIEF.md
# Four-Phase Handshake Two-Input Merge Cell

This cell combines two upstream word streams into one downstream stream. Each of its three ports uses a return-to-zero request/acknowledge handshake with four phases. First the request rises. Then the acknowledge rises. Then the request falls. Last, the acknowledge falls. No select input exists. Whichever upstream side raises its request is served, and when both request together the cell alternates between them. Because the cell chooses the source itself, trees of these cells can funnel many sources into one output.

The cell takes the word from the granted source into an internal register. It raises that source's acknowledge in the same clock edge as the register load, and it offers the stored word downstream at that same edge. It completes the upstream return-to-zero and the downstream return-to-zero independently. It takes no new word until both have finished. In this version the request and acknowledge lines are levels sampled on a single clock.

Top module: `hs_merge2`

## Requirements
- R1: During reset and right after it, `a_ack`, `b_ack` and `o_req` are low.
- R2: A word presented on side A alone is delivered unchanged once on `o_data`.
- R3: A word presented on side B alone is delivered unchanged once on `o_data`.
- R4: An upstream acknowledge rises only for a side whose request was high. When it rises, `o_req` is high and `o_data` already holds that side's word.
- R5: An upstream acknowledge stays high while its request stays high. It falls in the clock after the request is seen low.
- R6: While `o_req` is high and `o_ack` is low, `o_req` stays high and `o_data` does not change.
- R7: `o_req` falls only after `o_ack` has been seen high. No upstream acknowledge rises while `o_ack` is still high.
- R8: When both sides request continuously, consecutive output words alternate between side A and side B.
- R9: `a_ack` and `b_ack` are never high together.
- R10: Under random traffic on both inputs and random downstream delay, every word arrives exactly once, and each side's words arrive in the order sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_req | input | 1 | Side A request |
| a_data | input | DW | Side A word |
| a_ack | output | 1 | Side A acknowledge |
| b_req | input | 1 | Side B request |
| b_data | input | DW | Side B word |
| b_ack | output | 1 | Side B acknowledge |
| o_req | output | 1 | Output request |
| o_data | output | DW | Output word |
| o_ack | input | 1 | Output acknowledge |

## Verification
The merge is first driven from one side at a time. This shows that either input path forwards its word on its own. Then the downstream acknowledge is held back or kept high for several cycles. This separates a cell that holds its output and waits for the return-to-zero from one that moves on early. Both sides are then made to request continuously, which exposes a fixed-priority arbiter, because the source order fails to alternate. Last, random traffic under random back-pressure is checked per source for order and exact count, which catches lost or duplicated words.

// File: rtl/hs_merge2.sv
module hs_merge2 #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_req,
  input  logic [DW-1:0] a_data,
  output logic          a_ack,
  input  logic          b_req,
  input  logic [DW-1:0] b_data,
  output logic          b_ack,
  output logic          o_req,
  output logic [DW-1:0] o_data,
  input  logic          o_ack
);

  logic          busy, sel_b, prio_b, ack_q, oreq_q;
  logic [DW-1:0] word_q;

  wire req_g  = sel_b ? b_req : a_req;
  wire pick_b = b_req && (!a_req || prio_b);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      sel_b  <= 1'b0;
      prio_b <= 1'b0;
      ack_q  <= 1'b0;
      oreq_q <= 1'b0;
      word_q <= '0;
    end else if (!busy) begin
      if (a_req || b_req) begin
        busy   <= 1'b1;
        sel_b  <= pick_b;
        prio_b <= !pick_b;
        word_q <= pick_b ? b_data : a_data;
        ack_q  <= 1'b1;
        oreq_q <= 1'b1;
      end
    end else begin
      if (ack_q && !req_g) ack_q <= 1'b0;
      if (oreq_q && o_ack) oreq_q <= 1'b0;
      if (!ack_q && !oreq_q && !o_ack) busy <= 1'b0;
    end
  end

  assign a_ack  = ack_q && !sel_b;
  assign b_ack  = ack_q && sel_b;
  assign o_req  = oreq_q;
  assign o_data = word_q;

  p_ack_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_ack && b_ack));
  p_a_ack_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a_ack) |-> $past(a_req) && o_req && o_data == $past(a_data));
  p_b_ack_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(b_ack) |-> $past(b_req) && o_req && o_data == $past(b_data));
  p_a_ack_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ack && a_req) |=> a_ack);
  p_a_ack_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(a_ack) |-> !$past(a_req));
  p_b_ack_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(b_ack) |-> !$past(b_req));
  p_out_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (o_req && !o_ack) |=> (o_req && $stable(o_data)));
  p_oreq_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(o_req) |-> $past(o_ack));
  p_no_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(a_ack) || $rose(b_ack)) |-> !$past(o_ack));

endmodule

// File: tb/hs_merge2_bench.sv
module hs_merge2_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_req = 1'b0, b_req = 1'b0, o_ack = 1'b0;
  logic [15:0] a_data = '0, b_data = '0;
  logic a_ack, b_ack, o_req;
  logic [15:0] o_data;

  int checks = 0, failures = 0, excl_bad = 0;
  int c_lo = 0, c_hi = 0, c_hold = 0, c_cnt = 0;
  logic [15:0] rx [0:1023];
  int rx_n = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hs_merge2 #(.DW(16)) u_hs_merge2 (
    .clk(clk), .rst_n(rst_n),
    .a_req(a_req), .a_data(a_data), .a_ack(a_ack),
    .b_req(b_req), .b_data(b_data), .b_ack(b_ack),
    .o_req(o_req), .o_data(o_data), .o_ack(o_ack));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int pick_delay();
    return c_lo + int'($urandom % unsigned'(c_hi - c_lo + 1));
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (a_ack && b_ack) excl_bad++;
      if (o_req && !o_ack) begin
        if (c_cnt == 0) begin
          rx[rx_n] = o_data; rx_n++; o_ack = 1'b1; c_cnt = c_hold;
        end else c_cnt--;
      end else if (!o_req && o_ack) begin
        if (c_cnt == 0) begin
          o_ack = 1'b0; c_cnt = pick_delay();
        end else c_cnt--;
      end
    end
  end

  task automatic send_a(input logic [15:0] w, input int hold);
    @(negedge clk); a_data = w; a_req = 1'b1;
    while (!a_ack) @(negedge clk);
    chk(o_req && o_data == w, "R4 side A word present at ack", int'(o_data), int'(w));
    repeat (hold) @(negedge clk);
    a_req = 1'b0;
    while (a_ack) @(negedge clk);
  endtask

  task automatic send_b(input logic [15:0] w, input int hold);
    @(negedge clk); b_data = w; b_req = 1'b1;
    while (!b_ack) @(negedge clk);
    chk(o_req && o_data == w, "R4 side B word present at ack", int'(o_data), int'(w));
    repeat (hold) @(negedge clk);
    b_req = 1'b0;
    while (b_ack) @(negedge clk);
  endtask

  task automatic wait_rx(input int n);
    int t = 0;
    while (rx_n < n && t < 2000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(!a_ack && !b_ack && !o_req, "R1 outputs in reset", {a_ack, b_ack, o_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!a_ack && !b_ack && !o_req, "R1 outputs after reset", {a_ack, b_ack, o_req}, 0);
  endtask

  task automatic t_single;
    int s = rx_n;
    c_lo = 1; c_hi = 1;
    send_a(16'h0012, 0);
    wait_rx(s + 1);
    chk(rx_n == s + 1 && rx[s] == 16'h0012, "R2 side A word delivered once", int'(rx[s]), 16'h0012);
    s = rx_n;
    send_b(16'h80AB, 1);
    wait_rx(s + 1);
    chk(rx_n == s + 1 && rx[s] == 16'h80AB, "R3 side B word delivered once", int'(rx[s]), 16'h80AB);
  endtask

  task automatic t_ack_hold;
    a_data = 16'h0033; a_req = 1'b1;
    while (!a_ack) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(a_ack, "R5 ack held while req high", a_ack, 1);
    end
    a_req = 1'b0;
    @(negedge clk);
    chk(!a_ack, "R5 ack falls after req low", a_ack, 0);
    repeat (6) @(negedge clk);
  endtask

  task automatic t_backpressure;
    logic [15:0] first;
    c_lo = 6; c_hi = 6; c_cnt = 6;
    fork
      send_b(16'h8044, 0);
      begin
        while (!o_req) @(negedge clk);
        first = o_data;
        for (int i = 0; i < 5; i++) begin
          @(negedge clk);
          chk(o_req && !o_ack && o_data == first, "R6 output held under back-pressure",
              int'(o_data), int'(first));
        end
      end
    join
    wait_rx(rx_n);
    c_lo = 0; c_hi = 0;
  endtask

  task automatic t_rz_wait;
    int t;
    c_lo = 0; c_hi = 0; c_hold = 5;
    fork
      send_a(16'h0055, 0);
      begin
        while (!o_ack) @(negedge clk);
        @(negedge clk);
        chk(!o_req, "R7 o_req falls after o_ack", o_req, 0);
        c_hold = 0;
        b_data = 16'h8066; b_req = 1'b1;
        for (int i = 0; i < 3; i++) begin
          @(negedge clk);
          chk(!b_ack && o_ack, "R7 no grant while o_ack high", b_ack, 0);
        end
        t = 0;
        while (!b_ack && t < 10) begin @(negedge clk); t++; end
        chk(b_ack && t <= 4, "R7 grant after return to zero", t, 4);
        b_req = 1'b0;
        while (b_ack) @(negedge clk);
      end
    join
    wait_rx(rx_n);
  endtask

  task automatic t_alternate;
    int s = rx_n;
    int bad = 0;
    c_lo = 4; c_hi = 4;
    fork
      for (int i = 0; i < 4; i++) send_a(16'(i), 0);
      for (int i = 0; i < 4; i++) send_b(16'h8000 | 16'(i), 0);
    join
    wait_rx(s + 8);
    chk(rx_n == s + 8, "R8 eight words received", rx_n - s, 8);
    for (int i = s + 1; i < s + 8; i++) if (rx[i][15] == rx[i-1][15]) bad++;
    chk(bad == 0, "R8 sources alternate", bad, 0);
  endtask

  task automatic t_random;
    int s = rx_n;
    int exp_a = 0, exp_b = 0, err = 0;
    c_lo = 0; c_hi = 5;
    fork
      for (int i = 0; i < 40; i++) begin
        repeat ($urandom % 3) @(negedge clk);
        send_a(16'(i), int'($urandom % 4));
      end
      for (int i = 0; i < 40; i++) begin
        repeat ($urandom % 3) @(negedge clk);
        send_b(16'h8000 | 16'(i), int'($urandom % 4));
      end
    join
    wait_rx(s + 80);
    chk(rx_n == s + 80, "R10 total word count", rx_n - s, 80);
    for (int i = s; i < rx_n; i++) begin
      if (rx[i][15]) begin
        if (int'(rx[i][7:0]) != exp_b) err++;
        exp_b++;
      end else begin
        if (int'(rx[i][7:0]) != exp_a) err++;
        exp_a++;
      end
    end
    chk(err == 0, "R10 per-source order without loss or duplicate", err, 0);
    chk(exp_a == 40 && exp_b == 40, "R10 per-source counts", exp_a * 100 + exp_b, 4040);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    t_reset;
    t_single;
    t_ack_hold;
    t_backpressure;
    t_rz_wait;
    t_alternate;
    t_random;
    chk(excl_bad == 0, "R9 acks never together", excl_bad, 0);
    finish_run;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run;
  end
endmodule